// File: doc/BRIEF.md
# Biphase data line word extractor

This block sits behind an external data slicer that delivers a sliced bit stream together with a 5 MHz sampling clock. The payload runs at 2.5 Mbit/s and is biphase coded, so each data bit spans two clock cycles. During a window strobe that marks the one data-bearing line of the first field, the block looks for a fixed start code. Once that code is found it decodes the rest of the line into 8-bit words. Of those words it keeps five in a receive bank: word 5 and words 11 to 14.

Every half-bit pair is checked for a biphase violation. A line that decodes with no violation ends in a one-cycle transfer request, which tells downstream logic to copy the receive bank into its transmit bank. An active-LOW availability output falls after such a line and rises again at the next first-field start. When no fresh data is held, this output gives a single-cycle LOW pulse when the window opens, so a trigger edge is always present.

Top module: `dline_extract`

## Requirements
- R1: After reset, availN is 1, validPulse is 0, errFlag is 0 and rxBank is all zeros.
- R2: The start code is the parameter START_CODE, sent MSB first as 16 half-bit samples, where bit 1 is the pair 1 then 0 and bit 0 is the pair 0 then 1. Decoding starts only after all 16 samples match while lineWin is 1. The match may begin at any sample offset. If no match occurs before lineWin falls, or if the code differs in any bit, the line is abandoned: no validPulse and rxBank unchanged.
- R3: After the start code, words 3 to 15 follow, each 8 bits MSB first. Word 5 is stored in slot 0 and words 11, 12, 13 and 14 in slots 1 to 4. Slot k sits at rxBank bits 8k+7 down to 8k. All other words leave rxBank unchanged.
- R4: A pair with two equal halves is a biphase error. errFlag goes to 1 at that pair and stays 1 until the next window opens. A line with any error produces no validPulse.
- R5: On an error-free line, validPulse is 1 for exactly one cycle, in the cycle after the last half-bit of word 15 is sampled.
- R6: availN goes to 0 in the cycle after validPulse. It stays 0 until fieldStart is sampled high, and then reads 1.
- R7: The first clock edge with lineWin high in the idle state makes availN 0 for exactly one cycle, even when no valid data is held.
- R8: If lineWin falls before word 15 completes, the line is abandoned. There is no validPulse, and the stored slots keep the words that completed before the drop.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Data-line sampling clock (5 MHz nominal), rising edge |
| rstN | input | 1 | Asynchronous reset, active LOW |
| sampleIn | input | 1 | Sliced half-bit sample |
| lineWin | input | 1 | High during the data-bearing line of the first field |
| fieldStart | input | 1 | One-cycle pulse at the start of a first field |
| validPulse | output | 1 | One-cycle transfer request after an error-free line |
| errFlag | output | 1 | Biphase error seen in the current line |
| availN | output | 1 | Data available, active LOW |
| rxBank | output | 40 | Receive bank, slot k at bits 8k+7:8k |

## Verification
Several rules are checked on every cycle: the transfer request lasts one cycle and never coincides with a raised error flag, availability falls right after a request and rises after a field start, and the receive bank cannot change while the window is closed. The bench scenarios cover what needs a whole line to show. These are start-code matching at different sample offsets, rejection of a code that is wrong in one bit, the word-to-slot mapping across a sweep of word values, the trigger pulse when the window opens, and abandonment when the window closes mid-line. They also cover the effect of a biphase error placed in a word that is not stored.

// File: rtl/dline_pkg.sv
package dline_pkg;
  localparam int SLOT_W = 3;

  typedef struct packed {
    logic              clrLine;
    logic              shiftSrch;
    logic              takeHalf;
    logic              takeBit;
    logic              wordEnd;
    logic              wrEn;
    logic [SLOT_W-1:0] slot;
  } strobe_t;
endpackage

// File: rtl/dline_dpath.sv
module dline_dpath
  import dline_pkg::*;
#(
  parameter int WORD_W = 8,
  parameter int NUM_SLOTS = 5,
  parameter logic [WORD_W-1:0] START_CODE = 8'h8B
) (
  input  logic                        clk,
  input  logic                        rstN,
  input  logic                        sampleIn,
  input  strobe_t                     st,
  output logic                        match,
  output logic                        pairErr,
  output logic                        lineErr,
  output logic [NUM_SLOTS*WORD_W-1:0] rxBank
);
  localparam int PAT_W = 2 * WORD_W;

  function automatic logic [PAT_W-1:0] encodeCode(input logic [WORD_W-1:0] c);
    logic [PAT_W-1:0] enc;
    for (int i = 0; i < WORD_W; i++) enc[2*i +: 2] = c[i] ? 2'b10 : 2'b01;
    return enc;
  endfunction

  localparam logic [PAT_W-1:0] PATTERN = encodeCode(START_CODE);

  logic [PAT_W-1:0]  srch;
  logic [PAT_W-1:0]  srchNext;
  logic              hReg;
  logic [WORD_W-1:0] wordSh;
  logic [WORD_W-1:0] wordFull;

  assign srchNext = {srch[PAT_W-2:0], sampleIn};
  assign match    = (srchNext == PATTERN);
  assign pairErr  = st.takeBit && (hReg == sampleIn);
  assign wordFull = {wordSh[WORD_W-2:0], hReg};

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      srch    <= '0;
      hReg    <= 1'b0;
      wordSh  <= '0;
      lineErr <= 1'b0;
    end else begin
      if (st.clrLine) srch <= '0;
      else if (st.shiftSrch) srch <= srchNext;
      if (st.takeHalf) hReg <= sampleIn;
      if (st.takeBit) wordSh <= wordFull;
      if (st.clrLine) lineErr <= 1'b0;
      else if (pairErr) lineErr <= 1'b1;
    end
  end

  for (genvar k = 0; k < NUM_SLOTS; k++) begin : gSlot
    logic [WORD_W-1:0] slotReg;
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) slotReg <= '0;
      else if (st.wordEnd && st.wrEn && st.slot == SLOT_W'(k)) slotReg <= wordFull;
    end
    assign rxBank[k*WORD_W +: WORD_W] = slotReg;
  end
endmodule

// File: rtl/dline_ctrl.sv
module dline_ctrl
  import dline_pkg::*;
#(
  parameter int WORD_W = 8,
  parameter int NUM_WORDS = 15,
  parameter int FIRST_WORD = 3,
  parameter int SOLO_WORD = 5,
  parameter int RUN_FIRST = 11,
  parameter int NUM_SLOTS = 5
) (
  input  logic    clk,
  input  logic    rstN,
  input  logic    lineWin,
  input  logic    fieldStart,
  input  logic    match,
  input  logic    pairErr,
  input  logic    lineErr,
  output strobe_t st,
  output logic    validPulse,
  output logic    availN
);
  localparam int PAT_W = 2 * WORD_W;
  localparam int SC_W  = $clog2(PAT_W);
  localparam int BC_W  = $clog2(WORD_W);
  localparam int WC_W  = $clog2(NUM_WORDS + 1);
  localparam logic [SC_W-1:0] SC_MAX   = SC_W'(PAT_W - 1);
  localparam logic [BC_W-1:0] BC_LAST  = BC_W'(WORD_W - 1);
  localparam logic [WC_W-1:0] WC_LAST  = WC_W'(NUM_WORDS);
  localparam logic [WC_W-1:0] WC_FIRST = WC_W'(FIRST_WORD);
  localparam logic [WC_W-1:0] WC_SOLO  = WC_W'(SOLO_WORD);
  localparam logic [WC_W-1:0] WC_RUN0  = WC_W'(RUN_FIRST);
  localparam logic [WC_W-1:0] WC_RUNE  = WC_W'(RUN_FIRST + NUM_SLOTS - 1);

  typedef enum logic [1:0] {S_IDLE, S_SEARCH, S_DECODE, S_DONE} state_t;

  state_t          state, nextState;
  logic [SC_W-1:0] srchCnt;
  logic            half;
  logic [BC_W-1:0] bitCnt;
  logic [WC_W-1:0] wordCnt;
  logic            lastBit;
  logic            slotHit;
  logic [WC_W-1:0] runOff;
  logic            trigPulse;
  logic            availLow;

  assign slotHit = (wordCnt == WC_SOLO) || (wordCnt >= WC_RUN0 && wordCnt < WC_RUNE);
  assign runOff  = wordCnt - WC_RUN0 + WC_W'(1);

  always_comb begin
    st        = '0;
    nextState = state;
    lastBit   = 1'b0;
    unique case (state)
      S_IDLE: if (lineWin) begin
        st.clrLine = 1'b1;
        nextState  = S_SEARCH;
      end
      S_SEARCH: if (!lineWin) nextState = S_IDLE;
      else begin
        st.shiftSrch = 1'b1;
        if (match && srchCnt == SC_MAX) nextState = S_DECODE;
      end
      S_DECODE: if (!lineWin) nextState = S_IDLE;
      else if (!half) st.takeHalf = 1'b1;
      else begin
        st.takeBit = 1'b1;
        if (bitCnt == BC_LAST) begin
          st.wordEnd = 1'b1;
          st.wrEn    = slotHit;
          st.slot    = (wordCnt == WC_SOLO) ? '0 : SLOT_W'(runOff);
          if (wordCnt == WC_LAST) begin
            lastBit   = 1'b1;
            nextState = S_DONE;
          end
        end
      end
      S_DONE: if (!lineWin) nextState = S_IDLE;
      default: nextState = S_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state      <= S_IDLE;
      srchCnt    <= '0;
      half       <= 1'b0;
      bitCnt     <= '0;
      wordCnt    <= '0;
      validPulse <= 1'b0;
      trigPulse  <= 1'b0;
      availLow   <= 1'b0;
    end else begin
      state <= nextState;
      if (st.clrLine) srchCnt <= '0;
      else if (st.shiftSrch && srchCnt != SC_MAX) srchCnt <= srchCnt + SC_W'(1);
      if (state == S_SEARCH && nextState == S_DECODE) begin
        half    <= 1'b0;
        bitCnt  <= '0;
        wordCnt <= WC_FIRST;
      end else begin
        if (st.takeHalf) half <= 1'b1;
        if (st.takeBit) begin
          half   <= 1'b0;
          bitCnt <= bitCnt + BC_W'(1);
        end
        if (st.wordEnd) wordCnt <= wordCnt + WC_W'(1);
      end
      validPulse <= lastBit && !(lineErr || pairErr);
      trigPulse  <= (state == S_IDLE) && lineWin;
      if (validPulse) availLow <= 1'b1;
      else if (fieldStart) availLow <= 1'b0;
    end
  end

  assign availN = !(availLow || trigPulse);
endmodule

// File: rtl/dline_extract.sv
module dline_extract #(
  parameter int WORD_W = 8,
  parameter int NUM_WORDS = 15,
  parameter int FIRST_WORD = 3,
  parameter int SOLO_WORD = 5,
  parameter int RUN_FIRST = 11,
  parameter int NUM_SLOTS = 5,
  parameter logic [WORD_W-1:0] START_CODE = 8'h8B
) (
  input  logic                        clk,
  input  logic                        rstN,
  input  logic                        sampleIn,
  input  logic                        lineWin,
  input  logic                        fieldStart,
  output logic                        validPulse,
  output logic                        errFlag,
  output logic                        availN,
  output logic [NUM_SLOTS*WORD_W-1:0] rxBank
);
  dline_pkg::strobe_t st;
  logic match;
  logic pairErr;

  dline_ctrl #(
    .WORD_W(WORD_W), .NUM_WORDS(NUM_WORDS), .FIRST_WORD(FIRST_WORD),
    .SOLO_WORD(SOLO_WORD), .RUN_FIRST(RUN_FIRST), .NUM_SLOTS(NUM_SLOTS)
  ) i_ctrl (
    .clk(clk), .rstN(rstN), .lineWin(lineWin), .fieldStart(fieldStart),
    .match(match), .pairErr(pairErr), .lineErr(errFlag), .st(st),
    .validPulse(validPulse), .availN(availN)
  );

  dline_dpath #(
    .WORD_W(WORD_W), .NUM_SLOTS(NUM_SLOTS), .START_CODE(START_CODE)
  ) i_dpath (
    .clk(clk), .rstN(rstN), .sampleIn(sampleIn), .st(st),
    .match(match), .pairErr(pairErr), .lineErr(errFlag), .rxBank(rxBank)
  );
endmodule

// File: rtl/dline_checker.sv
module dline_checker #(
  parameter int BANK_W = 40
) (
  input logic              clk,
  input logic              rstN,
  input logic              lineWin,
  input logic              fieldStart,
  input logic              validPulse,
  input logic              errFlag,
  input logic              availN,
  input logic [BANK_W-1:0] rxBank
);
  AST_VALID_SINGLE: assert property (@(posedge clk) disable iff (!rstN)
    validPulse |=> !validPulse); // R5

  AST_VALID_CLEAN: assert property (@(posedge clk) disable iff (!rstN)
    validPulse |-> !errFlag); // R4

  AST_AVAIL_FALLS: assert property (@(posedge clk) disable iff (!rstN)
    validPulse |=> !availN); // R6

  AST_AVAIL_RISES: assert property (@(posedge clk) disable iff (!rstN)
    (fieldStart && !validPulse && !lineWin) |=> availN); // R6

  AST_BANK_HELD: assert property (@(posedge clk) disable iff (!rstN)
    !lineWin |=> $stable(rxBank)); // R8
endmodule

bind dline_extract dline_checker #(.BANK_W(NUM_SLOTS*WORD_W)) i_chk (
  .clk(clk), .rstN(rstN), .lineWin(lineWin), .fieldStart(fieldStart),
  .validPulse(validPulse), .errFlag(errFlag), .availN(availN), .rxBank(rxBank)
);

// File: tb/test_dline_extract.sv
module test_dline_extract;
  localparam logic [7:0] CODE = 8'h8B;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic sampleIn = 1'b0;
  logic lineWin = 1'b0;
  logic fieldStart = 1'b0;
  logic validPulse;
  logic errFlag;
  logic availN;
  logic [39:0] rxBank;
  logic [39:0] expBank = '0;
  int checks = 0;
  int failures = 0;
  int validSeen = 0;
  int validWant = 0;

  always #5 clk = ~clk;

  dline_extract i_dline_extract (
    .clk(clk), .rstN(rstN), .sampleIn(sampleIn), .lineWin(lineWin),
    .fieldStart(fieldStart), .validPulse(validPulse), .errFlag(errFlag),
    .availN(availN), .rxBank(rxBank)
  );

  always @(negedge clk) if (rstN && validPulse) validSeen++;

  task automatic check(input string req, input logic [39:0] act, input logic [39:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic int slotOf(input int w);
    if (w == 5) return 0;
    if (w >= 11 && w <= 14) return w - 10;
    return -1;
  endfunction

  function automatic logic [7:0] wordVal(input int l, input int w);
    if (slotOf(w) >= 0) return 8'((l * 5 + slotOf(w)) & 255);
    return 8'((l * 29 + w * 71) & 255);
  endfunction

  task automatic sendHalf(input logic b);
    @(negedge clk);
    sampleIn = b;
  endtask

  task automatic sendByte(input logic [7:0] v, input int badBit);
    for (int i = 7; i >= 0; i--) begin
      if (i == badBit) begin
        sendHalf(1'b1); sendHalf(1'b1);
      end else if (v[i]) begin
        sendHalf(1'b1); sendHalf(1'b0);
      end else begin
        sendHalf(1'b0); sendHalf(1'b1);
      end
    end
  endtask

  task automatic openField();
    @(negedge clk); fieldStart = 1'b1;
    @(negedge clk); fieldStart = 1'b0;
    check("R6 field start raises availN", 40'(availN), 40'd1);
  endtask

  task automatic openWindow();
    @(negedge clk); lineWin = 1'b1; sampleIn = 1'b0;
    @(negedge clk);
    check("R7 trigger pulse low", 40'(availN), 40'd0);
    @(negedge clk);
    check("R7 trigger pulse one cycle", 40'(availN), 40'd1);
  endtask

  task automatic closeWindow();
    @(negedge clk); lineWin = 1'b0; sampleIn = 1'b0;
    repeat (3) @(negedge clk);
  endtask

  task automatic runLine(input int l, input int errWord, input int dropWord);
    logic good;
    good = (errWord < 0) && (dropWord < 0);
    openField();
    openWindow();
    for (int z = 0; z < l % 5; z++) sendHalf(1'b0);
    sendByte(CODE, -1);
    for (int w = 3; w <= 15; w++) begin
      if (w == dropWord) begin
        @(negedge clk); lineWin = 1'b0;
        break;
      end
      sendByte(wordVal(l, w), (w == errWord) ? 3 : -1);
      if (slotOf(w) >= 0) expBank[slotOf(w)*8 +: 8] = wordVal(l, w);
    end
    @(negedge clk);
    check("R5 validPulse after word 15", 40'(validPulse), 40'(good));
    if (dropWord < 0) check("R4 errFlag after line", 40'(errFlag), 40'(errWord >= 0));
    if (good) validWant++;
    @(negedge clk);
    check("R5 validPulse single cycle", 40'(validPulse), 40'd0);
    check("R6 availN after line", 40'(availN), 40'(!good));
    check("R3 receive bank slots", rxBank, expBank);
    closeWindow();
    check("R6 availN held until field start", 40'(availN), 40'(!good));
    check(dropWord < 0 ? "R3 bank after window" : "R8 bank after drop", rxBank, expBank);
  endtask

  task automatic noMatchWindow(input logic nearMiss);
    openField();
    openWindow();
    if (nearMiss) sendByte(CODE ^ 8'h01, -1);
    for (int z = 0; z < 120; z++) sendHalf(1'b0);
    @(negedge clk);
    check("R2 no validPulse without start code", 40'(validPulse), 40'd0);
    check("R2 bank unchanged without start code", rxBank, expBank);
    closeWindow();
    check("R2 availN high after abandoned line", 40'(availN), 40'd1);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    check("R1 reset availN", 40'(availN), 40'd1);
    check("R1 reset validPulse", 40'(validPulse), 40'd0);
    check("R1 reset errFlag", 40'(errFlag), 40'd0);
    check("R1 reset rxBank", rxBank, 40'd0);
    rstN = 1'b1;
    repeat (2) @(negedge clk);
    noMatchWindow(1'b0);
    noMatchWindow(1'b1);
    for (int l = 0; l < 52; l++) begin
      if (l == 10) runLine(l, 7, -1);
      else if (l == 20) runLine(l, 15, -1);
      else if (l == 30) runLine(l, -1, 12);
      else runLine(l, -1, -1);
    end
    noMatchWindow(1'b1);
    check("R5 total transfer pulses", 40'(validSeen), 40'(validWant));
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    failures++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule